// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link. The link has an active-high transfer enable, a serial clock and one bidirectional data line. Each transfer opens with a command byte, sent least significant bit first. The command picks the clock-register space or the scratch-RAM space, a 5-bit address, and a read or a write. A single data byte follows, or a burst of bytes when the address is 31. The register set is as follows:

- seven clock registers,
- a control register that holds a write-protect flag,
- a charger configuration register,
- a scratch RAM of 31 bytes.

The block decodes the charger register into one enable output.

The whole block runs on a fast system clock. It passes the enable, serial clock and data-in through synchronisers and acts on the detected edges of the serial clock. It drives the data line through a separate output and output-enable. The pad that combines them sits outside the block.

Top module: `tw_regport`

## Requirements
- R1: The command byte is shifted in least significant bit first, and each bit is taken on a rising edge of the serial clock. Its fields are: bit 7 = write permission (1 allows writes), bit 6 = space (0 clock registers, 1 RAM), bits 5:1 = address, bit 0 = direction (0 write, 1 read).
- R2: In a single-byte write, the eight bits after the command are stored, LSB first, at the addressed location. Any further serial clocks in the same transfer change nothing.
- R3: In a read, data bits are presented LSB first. Each bit is driven after a falling edge, and the first bit follows the falling edge right after the eighth command bit. The output-enable drops after every rising edge. A single-byte read that continues past eight bits sends the same byte again.
- R4: A low transfer enable ends the transfer at once and drops the output-enable. A partly shifted data byte is then discarded.
- R5: A command whose bit 7 is 0 writes nothing.
- R6: Clock address 7 is the control register, and its bit 7 is write protect. While write protect is set, writes to every other location are blocked, but the control register stays writable. Bits 6:0 of the control register always read as 0.
- R7: A RAM burst (space 1, address 31) starts at RAM address 0. Each byte is stored as soon as its eighth bit arrives, so a burst that stops early keeps the bytes already completed.
- R8: A clock burst write (space 0, address 31) updates clock addresses 0 to 7 together, and only after all eight bytes have arrived. Nothing changes if fewer bytes arrive, or if write protect is set when the eighth byte completes.
- R9: Burst reads start at address 0 and advance by one per byte. A clock burst wraps from 7 back to 0 and never includes address 8. A RAM burst wraps from 30 back to 0.
- R10: Clock address 8 is the charger register, reached only by single-byte access. The charger enable output is high only when all three of these hold: bits 7:4 = 1010, bits 3:2 = 01 or 10, and bits 1:0 are not 00.
- R11: Clock addresses 9 to 30 store nothing and read as 0x00.
- R12: After reset, every register and RAM byte is 0, the charger enable is low and the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Transfer enable, active high |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data from the data line |
| ser_dout | output | 1 | Serial data to the data line |
| ser_doe | output | 1 | Output-enable for the data line |
| chg_on | output | 1 | Decoded charger enable |

## Verification
The data path is checked with a sweep that writes a distinct value to every RAM byte and every clock register, then reads each one back. Single-byte and burst transfers are both used, so an error in the address decoding or the bit order shows up as a wrong value at a known address. The gating paths are checked with these patterns:

- transfers cut short at the bit level and at the byte level,
- commands with the permission bit cleared,
- writes made while write protect is set,
- clock bursts of seven bytes and of eight bytes.

Each of these patterns shows whether a write was stored, staged or dropped. The charger register is swept through all 256 values, and the enable output is compared with the decode computed in the bench.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int ADDR_W     = 5;
  localparam int CLK_REGS   = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 5'd7;
  localparam logic [ADDR_W-1:0] CHG_ADDR   = 5'd8;
  localparam logic [ADDR_W-1:0] BURST_ADDR = 5'd31;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic ser_clk,
  input  logic ser_din,
  output logic en_s,
  output logic din_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic [2:0] raw;
  logic [STAGES-1:0] chain_q [3];
  logic sclk_prev_q;

  assign raw = {ser_en, ser_clk, ser_din};

  for (genvar g = 0; g < 3; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= '0;
      else        chain_q[g] <= {chain_q[g][STAGES-2:0], raw[g]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= chain_q[1][STAGES-1];
  end

  assign en_s      = chain_q[2][STAGES-1];
  assign din_s     = chain_q[0][STAGES-1];
  assign sclk_rise =  chain_q[1][STAGES-1] & ~sclk_prev_q;
  assign sclk_fall = ~chain_q[1][STAGES-1] &  sclk_prev_q;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
#(
  parameter int RAM_BYTES = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_ram,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      cm_en,
  input  logic [CLK_REGS-2:0][7:0]  cm_data,
  input  logic                      cm_wp,
  input  logic                      rd_ram,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  output logic                      wp,
  output logic                      chg_on
);
  logic [RAM_BYTES-1:0][7:0] ram_q, ram_d;
  logic [CLK_REGS-2:0][7:0]  clk_q, clk_d;
  logic                      wp_q, wp_d;
  logic [7:0]                chg_q, chg_d;

  always_comb begin
    ram_d = ram_q;
    clk_d = clk_q;
    wp_d  = wp_q;
    chg_d = chg_q;
    if (wr_en) begin
      if (wr_ram) begin
        for (int i = 0; i < RAM_BYTES; i++)
          if (wr_addr == ADDR_W'(i)) ram_d[i] = wr_data;
      end else begin
        for (int i = 0; i < CLK_REGS-1; i++)
          if (wr_addr == ADDR_W'(i)) clk_d[i] = wr_data;
        if (wr_addr == CTRL_ADDR) wp_d  = wr_data[7];
        if (wr_addr == CHG_ADDR)  chg_d = wr_data;
      end
    end
    if (cm_en) begin
      clk_d = cm_data;
      wp_d  = cm_wp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q <= '0;
      clk_q <= '0;
      wp_q  <= 1'b0;
      chg_q <= '0;
    end else if (wr_en || cm_en) begin
      ram_q <= ram_d;
      clk_q <= clk_d;
      wp_q  <= wp_d;
      chg_q <= chg_d;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_ram) begin
      for (int i = 0; i < RAM_BYTES; i++)
        if (rd_addr == ADDR_W'(i)) rd_data = ram_q[i];
    end else begin
      for (int i = 0; i < CLK_REGS-1; i++)
        if (rd_addr == ADDR_W'(i)) rd_data = clk_q[i];
      if (rd_addr == CTRL_ADDR) rd_data = {wp_q, 7'b0};
      if (rd_addr == CHG_ADDR)  rd_data = chg_q;
    end
  end

  assign wp     = wp_q;
  assign chg_on = (chg_q[7:4] == 4'b1010) &&
                  ((chg_q[3:2] == 2'b01) || (chg_q[3:2] == 2'b10)) &&
                  (chg_q[1:0] != 2'b00);

  AST_WP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ram || wr_addr != CTRL_ADDR)) |-> !wp_q);  // R6
  AST_COMMIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cm_en |-> !wp_q);  // R8
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_pkg::*;
#(
  parameter int RAM_BYTES = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_s,
  input  logic                      din_s,
  input  logic                      sclk_rise,
  input  logic                      sclk_fall,
  input  logic [7:0]                rd_data,
  input  logic                      wp,
  output logic                      rd_ram,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic                      wr_en,
  output logic                      wr_ram,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [7:0]                wr_data,
  output logic                      cm_en,
  output logic [CLK_REGS-2:0][7:0]  cm_data,
  output logic                      cm_wp,
  output logic                      dout,
  output logic                      doe
);
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_BYTES-1);
  localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'(CLK_REGS-1);

  phase_e                   phase_q, phase_d;
  logic [2:0]               bit_q, bit_d;
  logic [6:0]               sh_q, sh_d;
  logic [7:0]               byte_in;
  logic [ADDR_W-1:0]        addr_q, addr_d;
  logic                     ram_q, ram_d, burst_q, burst_d, wen_q, wen_d;
  logic [CLK_REGS-2:0][7:0] stage_q, stage_d;
  logic                     dout_q, dout_d, doe_q, doe_d;

  assign byte_in = {din_s, sh_q};

  always_comb begin
    phase_d = phase_q;  bit_d   = bit_q;   sh_d    = sh_q;
    addr_d  = addr_q;   ram_d   = ram_q;   burst_d = burst_q;
    wen_d   = wen_q;    stage_d = stage_q; dout_d  = dout_q;
    doe_d   = doe_q;
    wr_en   = 1'b0;
    cm_en   = 1'b0;
    if (!en_s) begin
      phase_d = PH_CMD;
      bit_d   = 3'd0;
      doe_d   = 1'b0;
    end else begin
      if (sclk_rise) doe_d = 1'b0;
      unique case (phase_q)
        PH_CMD: if (sclk_rise) begin
          sh_d  = byte_in[7:1];
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            wen_d   = byte_in[7];
            ram_d   = byte_in[6];
            burst_d = (byte_in[5:1] == BURST_ADDR);
            addr_d  = burst_d ? '0 : byte_in[5:1];
            phase_d = byte_in[0] ? PH_RD : PH_WR;
          end
        end
        PH_WR: if (sclk_rise) begin
          sh_d  = byte_in[7:1];
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (!burst_q) begin
              wr_en   = wen_q && (!wp || (!ram_q && addr_q == CTRL_ADDR));
              phase_d = PH_DONE;
            end else if (ram_q) begin
              wr_en = wen_q && !wp;
              if (addr_q == RAM_LAST) phase_d = PH_DONE;
              else                    addr_d  = addr_q + 1'b1;
            end else if (addr_q == CLK_LAST) begin
              cm_en   = wen_q && !wp;
              phase_d = PH_DONE;
            end else begin
              for (int i = 0; i < CLK_REGS-1; i++)
                if (addr_q == ADDR_W'(i)) stage_d[i] = byte_in;
              addr_d = addr_q + 1'b1;
            end
          end
        end
        PH_RD: begin
          if (sclk_fall) begin
            dout_d = rd_data[bit_q];
            doe_d  = 1'b1;
          end
          if (sclk_rise) begin
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7 && burst_q)
              addr_d = (addr_q == (ram_q ? RAM_LAST : CLK_LAST)) ? '0 : addr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;  bit_q   <= '0;  sh_q   <= '0;
      addr_q  <= '0;      ram_q   <= 1'b0; burst_q <= 1'b0;
      wen_q   <= 1'b0;    stage_q <= '0;  dout_q <= 1'b0;
      doe_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;  bit_q   <= bit_d;   sh_q   <= sh_d;
      addr_q  <= addr_d;   ram_q   <= ram_d;   burst_q <= burst_d;
      wen_q   <= wen_d;    stage_q <= stage_d; dout_q <= dout_d;
      doe_q   <= doe_d;
    end
  end

  assign rd_ram  = ram_q;
  assign rd_addr = addr_q;
  assign wr_ram  = ram_q;
  assign wr_addr = addr_q;
  assign wr_data = byte_in;
  assign cm_data = stage_q;
  assign cm_wp   = byte_in[7];
  assign dout    = dout_q;
  assign doe     = doe_q;

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !doe_q);  // R4
  AST_RISE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !doe_q);  // R3
  AST_BURST_CLK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_CMD && burst_q && !ram_q) |-> addr_q <= CLK_LAST);  // R9
endmodule

// File: rtl/tw_regport.sv
module tw_regport
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_BYTES   = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout,
  output logic ser_doe,
  output logic chg_on
);
  logic [1:0] rs_q;
  logic       rst_n_s;
  logic       en_s, din_s, sclk_rise, sclk_fall;
  logic       rd_ram, wr_en, wr_ram, cm_en, cm_wp, wp;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [CLK_REGS-2:0][7:0] cm_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  tw_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n_s), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_din), .en_s(en_s), .din_s(din_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall));

  tw_engine #(.RAM_BYTES(RAM_BYTES)) eng_i (
    .clk(clk), .rst_n(rst_n_s), .en_s(en_s), .din_s(din_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_data(rd_data),
    .wp(wp), .rd_ram(rd_ram), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_ram(wr_ram), .wr_addr(wr_addr), .wr_data(wr_data),
    .cm_en(cm_en), .cm_data(cm_data), .cm_wp(cm_wp),
    .dout(ser_dout), .doe(ser_doe));

  tw_regfile #(.RAM_BYTES(RAM_BYTES)) rf_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_ram(wr_ram),
    .wr_addr(wr_addr), .wr_data(wr_data), .cm_en(cm_en),
    .cm_data(cm_data), .cm_wp(cm_wp), .rd_ram(rd_ram),
    .rd_addr(rd_addr), .rd_data(rd_data), .wp(wp), .chg_on(chg_on));
endmodule

// File: tb/tw_regport_tb_top.sv
`timescale 1ns/1ps
module tw_regport_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, ser_en, ser_clk, ser_din;
  logic ser_dout, ser_doe, chg_on;
  int   nvec = 0, nerr = 0;
  bit   done = 0;

  logic [7:0] ram_m [31];
  logic [7:0] clk_m [7];
  logic       wp_m;
  logic [7:0] chg_m;

  always #2 clk = ~clk;

  tw_regport dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
    .chg_on(chg_on));

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cmdb(bit rd, bit ram, logic [4:0] a, bit en = 1'b1);
    return {en, ram, a, rd};
  endfunction

  function automatic logic [7:0] mread(bit ram, int a);
    if (ram) return (a < 31) ? ram_m[a] : 8'h00;
    if (a < 7) return clk_m[a];
    if (a == 7) return {wp_m, 7'b0};
    if (a == 8) return chg_m;
    return 8'h00;
  endfunction

  function automatic bit chg_exp(logic [7:0] v);
    return (v[7:4] == 4'b1010) && (v[3:2] == 2'b01 || v[3:2] == 2'b10) && (v[1:0] != 2'b00);
  endfunction

  task automatic sbit(bit b);
    ser_din = b; tick(HALF); ser_clk = 1'b1; tick(HALF); ser_clk = 1'b0;
  endtask

  task automatic sbyte(logic [7:0] b);
    for (int i = 0; i < 8; i++) sbit(b[i]);
  endtask

  task automatic rbyte(output logic [7:0] b, output bit oe_bad);
    oe_bad = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(HALF);
      if (ser_doe !== 1'b1) oe_bad = 1'b1;
      b[i] = ser_dout;
      ser_clk = 1'b1;
      tick(HALF);
      if (ser_doe !== 1'b0) oe_bad = 1'b1;
      ser_clk = 1'b0;
    end
  endtask

  task automatic open_x();
    ser_en = 1'b1; tick(HALF);
  endtask

  task automatic close_x();
    ser_din = 1'b0; ser_en = 1'b0; tick(HALF);
  endtask

  // single write with model update per R5/R6/R10/R11
  task automatic wr1(bit ram, int a, logic [7:0] d, bit en = 1'b1);
    open_x(); sbyte(cmdb(1'b0, ram, 5'(a), en)); sbyte(d); close_x();
    if (en && (!wp_m || (!ram && a == 7))) begin
      if (ram && a < 31) ram_m[a] = d;
      else if (!ram && a < 7) clk_m[a] = d;
      else if (!ram && a == 7) wp_m = d[7];
      else if (!ram && a == 8) chg_m = d;
    end
  endtask

  task automatic rd1(string req, bit ram, int a);
    logic [7:0] d; bit bad;
    open_x(); sbyte(cmdb(1'b1, ram, 5'(a))); rbyte(d, bad); close_x();
    check(req, d, mread(ram, a));
    check("R3 output-enable per bit", bad, 0);
  endtask

  initial begin
    logic [7:0] d; bit bad;
    for (int i = 0; i < 31; i++) ram_m[i] = 8'h00;
    for (int i = 0; i < 7; i++) clk_m[i] = 8'h00;
    wp_m = 1'b0; chg_m = 8'h00;
    rst_n = 1'b0; ser_en = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);

    // R12 reset state
    check("R12 doe after reset", ser_doe, 0);
    check("R12 chg_on after reset", chg_on, 0);
    for (int a = 0; a < 9; a++) rd1("R12 clock reg reset", 1'b0, a);

    // R1 R2 sweep over RAM and clock regs
    for (int a = 0; a < 31; a++) wr1(1'b1, a, 8'((a * 37 + 5) ^ 8'hA6));
    for (int a = 0; a < 31; a++) rd1("R2 RAM readback", 1'b1, a);
    for (int a = 0; a < 7; a++) wr1(1'b0, a, 8'(8'h91 + a * 19));
    for (int a = 0; a < 7; a++) rd1("R1 clock reg readback", 1'b0, a);

    // R2 extra clocks after data ignored
    open_x(); sbyte(cmdb(1'b0, 1'b1, 5'd5)); sbyte(8'h11); sbyte(8'hFF); close_x();
    ram_m[5] = 8'h11;
    rd1("R2 extra clocks ignored", 1'b1, 5);

    // R3 repeated single read
    open_x(); sbyte(cmdb(1'b1, 1'b1, 5'd3));
    rbyte(d, bad); check("R3 first byte", d, ram_m[3]);
    rbyte(d, bad); check("R3 repeated byte", d, ram_m[3]);
    check("R3 oe release", bad, 0);
    close_x();

    // R5 permission bit clear
    wr1(1'b1, 4, 8'h3C, 1'b0);
    rd1("R5 no write without bit 7", 1'b1, 4);

    // R4 abort mid-byte write and mid read
    open_x(); sbyte(cmdb(1'b0, 1'b1, 5'd6));
    for (int i = 0; i < 4; i++) sbit(1'b1);
    close_x();
    rd1("R4 partial byte discarded", 1'b1, 6);
    open_x(); sbyte(cmdb(1'b1, 1'b1, 5'd0)); tick(HALF);
    check("R4 doe driven before abort", ser_doe, 1);
    ser_en = 1'b0; tick(HALF);
    check("R4 doe released on enable low", ser_doe, 0);

    // R6 write protect
    wr1(1'b0, 7, 8'hFF);
    rd1("R6 control reads bit7 only", 1'b0, 7);
    wr1(1'b1, 2, 8'h77);
    rd1("R6 RAM write blocked", 1'b1, 2);
    wr1(1'b0, 1, 8'h55);
    rd1("R6 clock write blocked", 1'b0, 1);
    wr1(1'b0, 8, 8'hA5);
    rd1("R6 charger write blocked", 1'b0, 8);

    // R8 clock burst with WP set: nothing
    open_x(); sbyte(8'hBE);
    for (int i = 0; i < 8; i++) sbyte(8'h20 + 8'(i));
    close_x();
    for (int a = 0; a < 8; a++) rd1("R8 burst blocked by protect", 1'b0, a);
    wr1(1'b0, 7, 8'h00);
    rd1("R6 control writable under protect", 1'b0, 7);

    // R8 seven bytes only: nothing
    open_x(); sbyte(8'hBE);
    for (int i = 0; i < 7; i++) sbyte(8'h60 + 8'(i));
    close_x();
    for (int a = 0; a < 7; a++) rd1("R8 short burst no commit", 1'b0, a);
    // R8 full burst
    open_x(); sbyte(8'hBE);
    for (int i = 0; i < 7; i++) sbyte(8'h40 + 8'(i * 3));
    sbyte(8'h00);
    close_x();
    for (int i = 0; i < 7; i++) clk_m[i] = 8'h40 + 8'(i * 3);
    for (int a = 0; a < 8; a++) rd1("R8 full burst commit", 1'b0, a);

    // R10 set charger, then R9 clock burst read wraps without charger
    wr1(1'b0, 8, 8'hA5);
    open_x(); sbyte(8'hBF);
    for (int k = 0; k < 10; k++) begin
      rbyte(d, bad); check("R9 clock burst read", d, mread(1'b0, k % 8));
    end
    close_x();

    // R7 RAM burst write full then partial
    open_x(); sbyte(8'hFE);
    for (int i = 0; i < 31; i++) begin sbyte(8'(i * 11 + 1)); ram_m[i] = 8'(i * 11 + 1); end
    close_x();
    open_x(); sbyte(8'hFE);
    for (int i = 0; i < 3; i++) begin sbyte(8'hE0 + 8'(i)); ram_m[i] = 8'hE0 + 8'(i); end
    for (int i = 0; i < 5; i++) sbit(1'b0);
    close_x();
    // R9 RAM burst read wraps after 30
    open_x(); sbyte(8'hFF);
    for (int k = 0; k < 34; k++) begin
      rbyte(d, bad); check("R7 R9 RAM burst read", d, mread(1'b1, k % 31));
    end
    close_x();

    // R11 unimplemented
    wr1(1'b0, 12, 8'h5A);
    rd1("R11 unimplemented reads zero", 1'b0, 12);
    rd1("R11 unimplemented reads zero", 1'b0, 30);

    // R10 charger sweep
    for (int v = 0; v < 256; v++) begin
      wr1(1'b0, 8, 8'(v));
      check("R10 charger decode", chg_on, chg_exp(8'(v)));
      if (v % 51 == 0) rd1("R10 charger readback", 1'b0, 8);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule